// File: doc/BRIEF.md
# Pattern-Unlocked Serial Clock Register Port

This block hides a 64-bit timekeeping register image behind an ordinary byte-wide memory. Bus cycles are sampled on a clock: a write cycle is `ce_n` and `we_n` both low, and a read cycle is `ce_n` and `oe_n` low with `we_n` high. Each clock edge with one of these present counts as one bus cycle. Every cycle always reaches the backing memory. To reach the register image, software first issues a read, which arms the key comparator. It then issues 64 writes whose data bit 0 carries a fixed unlock key. Once the key has matched, the next 64 bus cycles move the image one bit per cycle through data bit 0.

If all 64 of those data cycles are writes, the collected bits replace the image at the end of the phase. Reads return the image one bit per cycle on bit 0, while bits 7:1 still come from memory. An abort input cancels recognition or transfer unless the image's own abort-disable bit is set.

The controller has three states. `ST_IDLE` waits for a read (transition *arm*). `ST_KEY` compares key bits: a read triggers *rearm*, a matching write triggers *advance*, the 64th matching write triggers *unlock*, and a wrong bit triggers *reject*. `ST_XFER` counts 64 data cycles and then returns to idle (*finish*). From any state, an effective abort triggers *abort* back to `ST_IDLE`.

Top module: `hidden_rtc_port`

## Requirements
- R1: After reset the controller is idle, `rdata` is 0 and the register image is all zeros.
- R2: Outside a data phase, a read returns on `rdata`, one clock after the read cycle, the byte last written at that address. Write cycles always update memory.
- R3: A read cycle in idle or during key recognition starts a new recognition attempt at key position 0.
- R4: The key is 64'h5CA33AC55CA33AC5. Bit n of this word must appear on `wdata[0]` at the n-th write after arming. A wrong bit returns the block to idle, and the image is left unchanged.
- R5: After the 64th matching key write, the next 64 bus cycles form the data phase. After the 64th data cycle, the block is idle again and reads return plain memory bytes.
- R6: On the k-th data cycle (k from 0), a read returns image bit k on `rdata[0]` one clock later. `rdata[7:1]` still carries memory bits 7:1 of the addressed byte.
- R7: On the k-th data cycle, a write supplies image bit k from `wdata[0]`. When all 64 data cycles are writes, the image is replaced at the end of the phase.
- R8: A data phase that is aborted, or that contains any read, leaves the image unchanged.
- R9: Bits that always read 0 are as follows: bit 7 of bytes 1 and 2; bits 7:6 of bytes 3 and 5; bits 7:6 and 3 of byte 4; bits 7:5 of byte 6. Byte n is image bits 8n+7:8n. The remaining-bit mask per byte 0..7 is FF,7F,7F,3F,37,3F,1F,FF.
- R10: `abort_req` high at a clock edge returns the block to idle from any state and takes priority over a bus cycle at the same edge.
- R11: When image bit 36 (abort disable) is 1, `abort_req` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| abort_req | input | 1 | Abort of recognition or transfer |

## Verification
The bench flips a single key bit at the first, middle and last positions. A comparator that ignored one position, or was off by one, would unlock anyway and overwrite the image. It also interrupts the key with a read and then sends the key from its start. A design that failed to rewind the position would reject this valid key. Data phases are cut short by abort, by a single read among writes, and by abort on a cycle with the disable bit set. Any premature commit, or any ignored disable bit, would show up in the image read back afterwards. Every address is swept through plain memory, and `rdata[7:1]` is checked during image reads, so a design that replaced the whole byte would fail.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
    localparam int IMG_W = 64;
    localparam int IDX_W = $clog2(IMG_W);
    localparam logic [IMG_W-1:0] UNLOCK_KEY = 64'h5CA33AC55CA33AC5;
    // bits forced to zero in the image (one bit per always-zero location)
    localparam logic [IMG_W-1:0] ZERO_BITS  = 64'h00E0C0C8C0808000;
    localparam logic [IMG_W-1:0] KEEP_MASK  = ~ZERO_BITS;
    localparam int HOLD_BIT = 36;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_KEY  = 2'd1,
        ST_XFER = 2'd2
    } seq_state_t;
endpackage

// File: rtl/hrp_mem.sv
module hrp_mem #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr) cells[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (rd) q <= cells[addr];
    end
endmodule

// File: rtl/hrp_seq.sv
module hrp_seq
    import hrp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  logic             wr,
    input  logic             din0,
    input  logic             abort_req,
    input  logic             hold,
    output seq_state_t       state,
    output logic [IDX_W-1:0] idx,
    output logic             xfer_wr,
    output logic             xfer_rd,
    output logic             commit
);
    seq_state_t       st_n;
    logic [IDX_W-1:0] idx_n;
    logic             all_wr, all_wr_n;
    logic             abort_eff;
    logic             last;

    assign abort_eff = abort_req && !hold;
    assign last      = (idx == IDX_W'(IMG_W - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx    <= '0;
            all_wr <= 1'b0;
        end else begin
            state  <= st_n;
            idx    <= idx_n;
            all_wr <= all_wr_n;
        end
    end

    always_comb begin
        st_n     = state;
        idx_n    = idx;
        all_wr_n = all_wr;
        if (abort_eff) begin
            st_n  = ST_IDLE;
            idx_n = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (rd) begin
                        st_n  = ST_KEY;
                        idx_n = '0;
                    end
                end
                ST_KEY: begin
                    if (rd) begin
                        idx_n = '0;
                    end else if (wr) begin
                        if (din0 == UNLOCK_KEY[idx]) begin
                            idx_n = idx + 1'b1;
                            if (last) begin
                                st_n     = ST_XFER;
                                all_wr_n = 1'b1;
                            end
                        end else begin
                            st_n  = ST_IDLE;
                            idx_n = '0;
                        end
                    end
                end
                ST_XFER: begin
                    if (rd || wr) begin
                        idx_n = idx + 1'b1;
                        if (rd) all_wr_n = 1'b0;
                        if (last) st_n = ST_IDLE;
                    end
                end
                default: begin
                    st_n  = ST_IDLE;
                    idx_n = '0;
                end
            endcase
        end
    end

    always_comb begin
        xfer_wr = (state == ST_XFER) && wr && !abort_eff;
        xfer_rd = (state == ST_XFER) && rd;
        commit  = xfer_wr && last && all_wr;
    end

    // R3: a read outside the data phase restarts recognition at position 0
    a_r3_read_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && state != ST_XFER && !abort_eff) |=> (state == ST_KEY && idx == '0));
    // R4: a wrong key bit drops to idle
    a_r4_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_KEY && wr && din0 != UNLOCK_KEY[idx] && !abort_eff) |=> state == ST_IDLE);
    // R5: the last matching key bit opens the data phase at position 0
    a_r5_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_KEY && wr && din0 == UNLOCK_KEY[idx] && last && !abort_eff)
        |=> (state == ST_XFER && idx == '0));
    // R5: the 64th data cycle ends the phase
    a_r5_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && (rd || wr) && last) |=> state == ST_IDLE);
    // R10: an effective abort always lands in idle
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        abort_eff |=> (state == ST_IDLE && idx == '0));
endmodule

// File: rtl/hrp_image.sv
module hrp_image
    import hrp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             shift_bit,
    input  logic [IDX_W-1:0] idx,
    input  logic             commit,
    output logic             out_bit,
    output logic             hold
);
    logic [IMG_W-1:0] stage_q, stage_n;
    logic [IMG_W-1:0] image_q;

    always_comb begin
        stage_n = stage_q;
        if (shift_en) stage_n[idx] = shift_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            image_q <= '0;
        end else begin
            stage_q <= stage_n;
            if (commit) image_q <= stage_n & KEEP_MASK;
        end
    end

    assign out_bit = image_q[idx];
    assign hold    = image_q[HOLD_BIT];

    // R8: the image moves only on a commit
    a_r8_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(image_q));
    // R9: always-zero locations stay zero after a commit
    a_r9_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ((image_q & ZERO_BITS) == '0));
endmodule

// File: rtl/hidden_rtc_port.sv
module hidden_rtc_port
    import hrp_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              abort_req
);
    logic             wr_cyc, rd_cyc;
    logic [7:0]       mem_q;
    seq_state_t       state;
    logic [IDX_W-1:0] idx;
    logic             xfer_wr, xfer_rd, commit;
    logic             img_bit, hold;
    logic             sel_img_q, img_bit_q;

    assign wr_cyc = !ce_n && !we_n;
    assign rd_cyc = !ce_n && we_n && !oe_n;

    hrp_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr(wr_cyc), .rd(rd_cyc),
        .addr(addr), .wdata(wdata), .q(mem_q)
    );

    hrp_seq u_seq (
        .clk(clk), .rst_n(rst_n), .rd(rd_cyc), .wr(wr_cyc), .din0(wdata[0]),
        .abort_req(abort_req), .hold(hold), .state(state), .idx(idx),
        .xfer_wr(xfer_wr), .xfer_rd(xfer_rd), .commit(commit)
    );

    hrp_image u_image (
        .clk(clk), .rst_n(rst_n), .shift_en(xfer_wr), .shift_bit(wdata[0]),
        .idx(idx), .commit(commit), .out_bit(img_bit), .hold(hold)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_img_q <= 1'b0;
            img_bit_q <= 1'b0;
        end else if (rd_cyc) begin
            sel_img_q <= xfer_rd;
            img_bit_q <= img_bit;
        end
    end

    assign rdata = {mem_q[7:1], sel_img_q ? img_bit_q : mem_q[0]};

    // R1: reset leaves the controller idle
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> state == ST_IDLE);
    // R6: upper data bits always come from memory
    a_r6_upper_from_mem: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[7:1] == mem_q[7:1]);
endmodule

// File: tb/hidden_rtc_port_tb.sv
module hidden_rtc_port_tb;
    localparam int AW = 6;
    localparam logic [63:0] KEY = 64'h5CA33AC55CA33AC5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, abort_req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mem_m [64];
    logic [63:0] img_m = '0;

    always #2 clk = ~clk;

    hidden_rtc_port #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .abort_req(abort_req)
    );

    function automatic logic [63:0] keep_mask();
        logic [7:0] m [8] = '{8'hFF, 8'h7F, 8'h7F, 8'h3F, 8'h37, 8'h3F, 8'h1F, 8'hFF};
        logic [63:0] r = '0;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = m[b];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 0; we_n = 0; oe_n = 1; addr = a; wdata = d;
        @(negedge clk);
        ce_n = 1; we_n = 1;
        mem_m[a] = d;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        ce_n = 0; we_n = 1; oe_n = 0; addr = a;
        @(negedge clk);
        ce_n = 1; oe_n = 1;
        d = rdata;
    endtask

    task automatic pulse_abort();
        @(negedge clk);
        abort_req = 1;
        @(negedge clk);
        abort_req = 0;
    endtask

    task automatic send_key(input int from, input int upto, input int flip);
        for (int i = from; i < upto; i++) bus_wr(0, {7'h0, KEY[i] ^ (i == flip)});
    endtask

    task automatic unlock();
        logic [7:0] d;
        bus_rd(1, d);
        send_key(0, 64, -1);
    endtask

    task automatic data_writes(input logic [63:0] v, input int from, input int upto);
        for (int i = from; i < upto; i++) bus_wr(2, {7'h0, v[i]});
    endtask

    task automatic read_image(input string req, output logic [63:0] v);
        logic [7:0] d;
        unlock();
        for (int i = 0; i < 64; i++) begin
            bus_rd(9, d);
            v[i] = d[0];
            if (d[7:1] != mem_m[9][7:1])
                chk(0, req, {57'h0, d[7:1]}, {57'h0, mem_m[9][7:1]});
        end
    endtask

    task automatic check_image(input string req);
        logic [63:0] v;
        read_image(req, v);
        chk(v == img_m, req, v, img_m);
    endtask

    task automatic load_image(input logic [63:0] v);
        unlock();
        data_writes(v, 0, 64);
        img_m = v & keep_mask();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [7:0] d;
        logic [63:0] pats [4] = '{64'hFFFFFFFFFFFFFFFF, 64'hAAAA5555AAAA5555,
                                  64'h8000000000000001, 64'h0123456789ABCDEF};
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(rdata == 8'h00, "R1 rdata", {56'h0, rdata}, 64'h0);
        bus_wr(9, 8'hA4);
        check_image("R1 image after reset");

        // R2 memory sweep
        for (int a = 0; a < 64; a++) bus_wr(AW'(a), 8'(a * 37 + 5));
        for (int a = 0; a < 64; a++) begin
            bus_rd(AW'(a), d);
            chk(d == mem_m[a], "R2 memory read", {56'h0, d}, {56'h0, mem_m[a]});
        end

        // R7 R9 R6 image writes and read back (bits 7:1 from memory)
        bus_wr(9, 8'h5B);
        foreach (pats[p]) begin
            load_image(pats[p]);
            check_image("R7 R9 R6 image round trip");
        end

        // R5 after the data phase, reads are plain memory again
        unlock();
        data_writes(64'h0, 0, 0);
        for (int i = 0; i < 64; i++) bus_rd(9, d);
        bus_rd(3, d);
        chk(d == mem_m[3], "R5 idle after phase", {56'h0, d}, {56'h0, mem_m[3]});

        // R4 single flipped key bit rejects
        foreach (pats[p]) begin
            int fl;
            fl = (p == 0) ? 0 : (p == 1) ? 31 : (p == 2) ? 63 : 17;
            bus_rd(1, d);
            send_key(0, 64, fl);
            data_writes(64'h0F0F0F0F0F0F0F0F, 0, 64);
            bus_rd(3, d);
            chk(d == mem_m[3], "R4 no data phase", {56'h0, d}, {56'h0, mem_m[3]});
            check_image("R4 image kept");
        end

        // R3 a read mid-key restarts at position 0
        bus_rd(1, d);
        send_key(0, 20, -1);
        bus_rd(1, d);
        send_key(0, 64, -1);
        data_writes(64'h0000_0000_1122_3344, 0, 64);
        img_m = 64'h0000_0000_1122_3344 & keep_mask();
        check_image("R3 rearm then unlock");

        // R8 R10 abort mid data phase
        unlock();
        data_writes(64'h0000_00EE_0000_0011, 0, 30);
        pulse_abort();
        bus_rd(3, d);
        chk(d == mem_m[3], "R10 idle after abort", {56'h0, d}, {56'h0, mem_m[3]});
        check_image("R8 abort keeps image");

        // R10 abort during key recognition
        bus_rd(1, d);
        send_key(0, 32, -1);
        pulse_abort();
        send_key(32, 64, -1);
        data_writes(64'h0000_0000_0000_00FF, 0, 64);
        check_image("R10 abort in key");

        // R10 abort at the same edge as the last data write wins
        unlock();
        data_writes(64'h0000_0000_0000_0022, 0, 63);
        @(negedge clk);
        ce_n = 0; we_n = 0; wdata = 8'h0; addr = 2; abort_req = 1;
        @(negedge clk);
        ce_n = 1; we_n = 1; abort_req = 0; mem_m[2] = 8'h0;
        check_image("R10 abort beats commit");

        // R8 one read among the data writes blocks the commit
        unlock();
        data_writes(64'h0000_0000_0000_0033, 0, 40);
        bus_rd(9, d);
        data_writes(64'h0000_0000_0000_0033, 41, 64);
        check_image("R8 mixed phase");

        // R11 abort ignored with disable bit set
        load_image(64'h0000_0010_0000_0001);
        chk(img_m[36] == 1'b1, "R11 setup", {63'h0, img_m[36]}, 64'h1);
        unlock();
        data_writes(64'h0000_0017_0000_0055, 0, 30);
        pulse_abort();
        data_writes(64'h0000_0017_0000_0055, 30, 64);
        img_m = 64'h0000_0017_0000_0055 & keep_mask();
        check_image("R11 abort ignored");
        load_image(64'h0);
        check_image("R11 cleared");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule